// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches for software that has stopped making progress. A 12-bit counter counts down at a rate set by a 3-bit divider setting. Software must restart the counter with a keyed kick strobe before it passes zero. It must not kick too soon either: a kick that arrives while the count is still above a programmed window limit is treated as a fault. Either fault gives a one-cycle reset request. After that request, the counter starts again from the reload value.

Four configuration registers sit behind a simple write strobe: reload value, window limit, control (enable and divider), and a lock. The reload, window and control registers accept writes only while the lock is open. A debug-halt input freezes the count and the divider while a debugger holds the processor. The block has no data stream, so every pin is a plain control or status signal with no valid/ready handshake. A write or a kick takes effect on the clock edge where its strobe is high.

Top module: `win_watchdog`

## Requirements
- R1: After reset, `rst_req` is low, the block is disabled, and it produces no pulse until it is enabled.
- R2: After reset the lock is closed. While it is closed, writes to address 0 (reload, bits 11:0), address 1 (window limit, bits 11:0) and address 2 (control: bit 0 enable, bits 3:1 divider setting) have no effect.
- R3: A write to address 3 with the value 0x6D2B opens the lock. A write to address 3 with any other value closes it.
- R4: With divider setting n, the count steps once every 2^n enabled cycles. Starting from the edge that enables the block, the first underflow pulse follows (reload+1)·2^n cycles later.
- R5: When the count is 0 and a step falls due, `rst_req` goes high for the next cycle and the count restarts from the reload value, so each later period has the same length.
- R6: A kick with key 0xC3A5 while enabled and with the count at or below the window limit reloads the counter and produces no pulse.
- R7: A kick with key 0xC3A5 while enabled and with the count above the window limit produces a `rst_req` pulse in the next cycle and reloads the counter.
- R8: A kick carrying any other key is ignored: no pulse, and the underflow timing is unchanged.
- R9: While `dbg_halt` is high, the count and the divider hold. The period is stretched by exactly the number of halted cycles.
- R10: Each `rst_req` pulse caused by underflow or an early kick lasts one cycle, as long as the reload value is non-zero.
- R11: While disabled, the counter is held at the reload value and kicks are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 reload, 1 window, 2 control, 3 lock |
| cfg_wdata | input | 16 | Write data |
| kick | input | 1 | Reload strobe |
| kick_key | input | 16 | Key that goes with the reload strobe |
| dbg_halt | input | 1 | Freeze counting while high |
| rst_req | output | 1 | Single-cycle reset request |

## Verification
On every cycle, the assertions check these behaviours:
- a locked register file does not change;
- a keyed kick gives a pulse exactly when the count is above the limit;
- an in-window kick loads the reload value;
- a due step at zero gives a pulse;
- a halted counter holds;
- pulses are single and nothing fires while disabled.

Period lengths for each divider setting, the restart after a pulse, the stretch caused by a halt window, and the way the lock key opens and closes can only be shown by the bench's scenarios, which measure the distance between pulses at the output.

// File: rtl/wd_pkg.sv
package wd_pkg;
  parameter int CNT_W = 12;
  parameter int PSC_W = 3;
  parameter int KEY_W = 16;
  parameter int DIV_W = (1 << PSC_W) - 1;

  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_WINDOW = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_LOCK   = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] limit;
    logic [PSC_W-1:0] psc;
    logic             run;
  } cfg_t;
endpackage

// File: rtl/wd_cfg_regs.sv
module wd_cfg_regs
  import wd_pkg::*;
#(
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'h6D2B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [KEY_W-1:0] wdata,
  output cfg_t             cfg,
  output logic             unlocked
);
  cfg_sel_e sel;
  logic     open_q;
  cfg_t     cfg_q;

  assign sel = cfg_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else if (we && sel == SEL_LOCK) begin
      open_q <= (wdata == UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.reload <= '1;
      cfg_q.limit  <= '1;
      cfg_q.psc    <= '0;
      cfg_q.run    <= 1'b0;
    end else if (we && open_q) begin
      unique case (sel)
        SEL_RELOAD: cfg_q.reload <= wdata[CNT_W-1:0];
        SEL_WINDOW: cfg_q.limit  <= wdata[CNT_W-1:0];
        SEL_CTRL: begin
          cfg_q.run <= wdata[0];
          cfg_q.psc <= wdata[PSC_W:1];
        end
        default: ;
      endcase
    end
  end

  assign cfg      = cfg_q;
  assign unlocked = open_q;
endmodule

// File: rtl/wd_tick_gen.sv
module wd_tick_gen
  import wd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic             clear,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [DIV_W-1:0] pc_q;
  logic [DIV_W-1:0] mask;
  logic             active;

  assign mask   = ~({DIV_W{1'b1}} << psc);
  assign active = run && !hold;
  assign tick   = active && ((pc_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (clear) begin
      pc_q <= '0;
    end else if (active) begin
      pc_q <= pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/wd_countdown.sv
module wd_countdown
  import wd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             kick_ok,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             restart,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign restart = run && (kick_ok || (tick && at_zero));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      fire_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= reload;
      fire_q <= 1'b0;
    end else if (kick_ok) begin
      cnt_q  <= reload;
      fire_q <= (cnt_q > limit);
    end else if (tick) begin
      if (at_zero) begin
        cnt_q  <= reload;
        fire_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
        fire_q <= 1'b0;
      end
    end else begin
      fire_q <= 1'b0;
    end
  end

  assign count = cnt_q;
  assign fire  = fire_q;
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wd_pkg::*;
#(
  parameter logic [KEY_W-1:0] KICK_KEY   = 16'hC3A5,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'h6D2B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [KEY_W-1:0] cfg_wdata,
  input  logic             kick,
  input  logic [KEY_W-1:0] kick_key,
  input  logic             dbg_halt,
  output logic             rst_req
);
  cfg_t             cfg;
  logic             unlocked;
  logic             tick;
  logic             kick_ok;
  logic             restart;
  logic [CNT_W-1:0] count;

  assign kick_ok = kick && (kick_key == KICK_KEY);

  wd_cfg_regs #(.UNLOCK_KEY(UNLOCK_KEY)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .cfg      (cfg),
    .unlocked (unlocked)
  );

  wd_tick_gen u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (cfg.run),
    .hold  (dbg_halt),
    .clear (!cfg.run || restart),
    .psc   (cfg.psc),
    .tick  (tick)
  );

  wd_countdown u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg.run),
    .tick    (tick),
    .kick_ok (kick_ok),
    .reload  (cfg.reload),
    .limit   (cfg.limit),
    .count   (count),
    .restart (restart),
    .fire    (rst_req)
  );
endmodule

// File: rtl/wd_checker.sv
module wd_checker
  import wd_pkg::*;
#(
  parameter logic [KEY_W-1:0] KICK_KEY = 16'hC3A5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic             kick,
  input logic [KEY_W-1:0] kick_key,
  input logic             dbg_halt,
  input logic             rst_req,
  input logic [CNT_W-1:0] count,
  input cfg_t             cfg,
  input logic             unlocked,
  input logic             tick
);
  logic good_kick;
  assign good_kick = kick && (kick_key == KICK_KEY);

  AST_LOCKED_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && cfg_we && cfg_addr != 2'd3) |=> $stable(cfg)); // R2

  AST_EARLY_KICK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.run && good_kick && count > cfg.limit) |=> rst_req); // R7

  AST_WINDOW_KICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.run && good_kick && count <= cfg.limit) |=> (!rst_req && count == $past(cfg.reload))); // R6

  AST_ZERO_STEP_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.run && tick && count == '0 && !good_kick) |=> rst_req); // R5

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.run && dbg_halt && !good_kick && !cfg_we) |=> $stable(count)); // R9

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !good_kick && count != '0) |=> !rst_req); // R10

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.run |=> !rst_req); // R11
endmodule

bind win_watchdog wd_checker #(.KICK_KEY(KICK_KEY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .kick     (kick),
  .kick_key (kick_key),
  .dbg_halt (dbg_halt),
  .rst_req  (rst_req),
  .count    (count),
  .cfg      (cfg),
  .unlocked (unlocked),
  .tick     (tick)
);

// File: tb/tb_win_watchdog.sv
module tb_win_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] KK = 16'hC3A5;
  localparam logic [15:0] UK = 16'h6D2B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        kick = 1'b0;
  logic [15:0] kick_key = '0;
  logic        dbg_halt = 1'b0;
  logic        rst_req;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_watchdog dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .kick(kick), .kick_key(kick_key),
    .dbg_halt(dbg_halt), .rst_req(rst_req)
  );

  function automatic int period(int r, int n);
    return (r + 1) << n;
  endfunction

  function automatic bit early(int cnt, int lim);
    return cnt > lim;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // All tasks are entered at a negedge and return at a negedge.
  task automatic cfg_wr(logic [1:0] a, logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic kick_it(logic [15:0] key);
    kick = 1'b1; kick_key = key;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic wait_pulse(int limit, output int k);
    k = 0;
    while (k < limit) begin
      @(negedge clk);
      k++;
      if (rst_req) return;
    end
    k = -1;
  endtask

  task automatic quiet(int n, string tag);
    int seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (rst_req) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic restart(int r, int w, int n);
    cfg_wr(2'd2, 16'((n << 1)));
    cfg_wr(2'd0, 16'(r));
    cfg_wr(2'd1, 16'(w));
    cfg_wr(2'd2, 16'((n << 1) | 1));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(rst_req == 1'b0, "R1 reset level", int'(rst_req), 0);
    quiet(20, "R1 no pulse after reset");

    // R2: locked after reset, enable write ignored
    cfg_wr(2'd0, 16'd3);
    cfg_wr(2'd2, 16'd1);
    quiet(60, "R2 locked writes ignored");

    // R3 unlock, R4 first period
    cfg_wr(2'd3, UK);
    restart(5, 12'hFFF, 0);
    wait_pulse(100, k);
    chk(k == period(5, 0), "R3 R4 unlock then period", k, period(5, 0));
    // R3 close with another value, disable attempt ignored
    cfg_wr(2'd3, 16'h0000);
    cfg_wr(2'd2, 16'h0000);
    wait_pulse(100, k);
    chk(k == period(5, 0) - 2, "R3 relock keeps config", k, period(5, 0) - 2);
    cfg_wr(2'd3, UK);

    // R4 R5 R10 random periods
    for (int t = 0; t < 8; t++) begin
      int r = 1 + int'($urandom % 20);
      int n = int'($urandom % 8);
      restart(r, 12'hFFF, n);
      wait_pulse(5000, k);
      chk(k == period(r, n), "R4 first period", k, period(r, n));
      @(negedge clk);
      chk(rst_req == 1'b0, "R10 pulse width", int'(rst_req), 0);
      wait_pulse(5000, k);
      chk(k == period(r, n) - 1, "R5 restart period", k, period(r, n) - 1);
    end

    // R6 kick at limit, then reload visible in next period
    restart(100, 50, 0);
    repeat (50) @(negedge clk);
    kick_it(KK);
    chk(rst_req == 1'b0, "R6 in-window kick", int'(rst_req), 0);
    wait_pulse(500, k);
    chk(k == 101, "R6 reload after kick", k, 101);
    // R7 kick one above limit
    repeat (49) @(negedge clk);
    kick_it(KK);
    chk(rst_req == 1'b1, "R7 early kick pulse", int'(rst_req), 1);
    wait_pulse(500, k);
    chk(k == 101, "R7 reload after early kick", k, 101);

    // R6 R7 random kick points
    for (int t = 0; t < 6; t++) begin
      int r = 60 + int'($urandom % 40);
      int w = int'($urandom % r);
      int m = int'($urandom % r);
      restart(r, w, 0);
      repeat (m) @(negedge clk);
      kick_it(KK);
      chk(rst_req == early(r - m, w), "R6 R7 random kick", int'(rst_req), int'(early(r - m, w)));
    end

    // R8 wrong key
    restart(30, 10, 0);
    repeat (5) @(negedge clk);
    kick_it(16'h0000);
    chk(rst_req == 1'b0, "R8 wrong key no pulse", int'(rst_req), 0);
    wait_pulse(500, k);
    chk(k == period(30, 0) - 6, "R8 timing unchanged", k, period(30, 0) - 6);

    // R9 debug halt stretches by 50 cycles
    restart(20, 12'hFFF, 1);
    k = 0;
    while (k < 1000) begin
      @(negedge clk);
      k++;
      if (k == 10) dbg_halt = 1'b1;
      if (k == 60) dbg_halt = 1'b0;
      if (rst_req) break;
    end
    chk(k == period(20, 1) + 50, "R9 halt stretch", k, period(20, 1) + 50);

    // R11 disabled: kick ignored, counter held at reload
    cfg_wr(2'd2, 16'h0000);
    kick_it(KK);
    quiet(100, "R11 disabled quiet");
    cfg_wr(2'd2, 16'h0001);
    wait_pulse(500, k);
    chk(k == period(20, 0), "R11 held at reload", k, period(20, 0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule